// File: doc/BRIEF.md
# Sampled Pin Glitch Filter with Edge Events

This block conditions an asynchronous external request pin before edge detection. The pin first crosses into the system clock domain through a two-flop synchronizer. The synchronized level is then either passed straight through or sampled on a slow enable from a free-running divider. A new level is adopted only when three successive samples all show it, so that short glitches never reach the interrupt logic.

The block keeps a filtered level and issues a one-cycle edge event whenever that level changes, subject to an edge selection. The selection is either one chosen polarity or both directions. The event feeds the interrupt request logic and the interval measurement counter beside this block. After reset the filtered level takes over the synchronized pin value quietly, so a pin that idles high does not produce a false edge.

Top module: `pin_glitch_filter`

## Requirements
- R1: With `rate_sel` = 00, a pin change that is set up before a rising clock edge appears on `level_out`, together with its event, right after the third rising edge counted from that one (two synchronizer flops plus the level register).
- R2: `rate_sel` picks the sampling enable from a free-running divider that is cleared by reset. 01 samples once every 2 clocks, 10 once every 8, and 11 once every 32.
- R3: With filtering on (`rate_sel` not 00), a level is adopted only when the last three samples agree. A pin pulse lasting at most two sample periods (2N clocks) leaves `level_out` unchanged and raises no event.
- R4: With filtering on, a pin level held for three sample periods (3N clocks) is adopted. Its event arrives between 2N+3 and 3N+2 clocks after the pin change was driven.
- R5: In bypass mode every synchronized change passes, including a pin pulse only one clock wide, which gives two events on consecutive clocks.
- R6: With `both_edges` = 1, both rising and falling changes of `level_out` raise `edge_evt`.
- R7: With `both_edges` = 0, `edge_evt` is raised only on rising changes when `rise_sel` = 1, and only on falling changes when `rise_sel` = 0. `level_out` follows the pin in both directions regardless.
- R8: `edge_evt` is high for exactly the clock cycle in which `level_out` shows its new value, and never when `level_out` did not change.
- R9: During reset `level_out` and `edge_evt` are 0. After reset `level_out` takes the first synchronized pin value without raising `edge_evt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous external pin |
| rate_sel | input | 2 | Sampling rate: 00 bypass, 01 clk/2, 10 clk/8, 11 clk/32 |
| rise_sel | input | 1 | Polarity used when `both_edges` is 0: 1 rising, 0 falling |
| both_edges | input | 1 | 1 raises events on both directions |
| level_out | output | 1 | Filtered pin level |
| edge_evt | output | 1 | One-cycle edge event |

## Verification
The bench drives pulses of exactly 2N clocks, the longest that must be rejected, at each rate. A filter that counted two agreeing samples instead of three, or sampled at the wrong divider tap, would let such a pulse through and produce an unexpected event. Pulses of 3N clocks must give events inside the latency window for their rate, which catches a swapped rate decode or a missing synchronizer stage. It also holds the pin high through reset to catch a false edge at start-up, and sends one-clock pulses in bypass, where a design that dropped back-to-back changes would lose the second event. Each polarity setting is exercised, and a design with an inverted `rise_sel` would report events of the wrong direction.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
   localparam logic [1:0] RATE_OFF   = 2'b00;
   localparam logic [1:0] RATE_DIV_A = 2'b01;
   localparam logic [1:0] RATE_DIV_B = 2'b10;
   localparam logic [1:0] RATE_DIV_C = 2'b11;
endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic vld
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pgf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sr;
   logic [STAGES-1:0] vsr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr  <= '0;
         vsr <= '0;
      end else begin
         sr  <= {sr[STAGES-2:0], d};
         vsr <= {vsr[STAGES-2:0], 1'b1};
      end
   end

   assign q   = sr[STAGES-1];
   assign vld = vsr[STAGES-1];
endmodule

// File: rtl/pgf_tick.sv
module pgf_tick #(
   parameter int DIV_W = 5,
   parameter int SH_A  = 1,
   parameter int SH_B  = 3,
   parameter int SH_C  = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   output logic       tick
);
   import pgf_pkg::*;

   localparam logic [DIV_W-1:0] MASK_A = DIV_W'((1 << SH_A) - 1);
   localparam logic [DIV_W-1:0] MASK_B = DIV_W'((1 << SH_B) - 1);
   localparam logic [DIV_W-1:0] MASK_C = DIV_W'((1 << SH_C) - 1);

   generate
      if (!(SH_A > 0 && SH_A < SH_B && SH_B < SH_C && SH_C <= DIV_W)) begin : g_bad_shift
         $error("pgf_tick: need 0 < SH_A < SH_B < SH_C <= DIV_W");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   always_comb begin
      unique case (sel)
         RATE_DIV_A: tick = ((cnt & MASK_A) == MASK_A);
         RATE_DIV_B: tick = ((cnt & MASK_B) == MASK_B);
         RATE_DIV_C: tick = ((cnt & MASK_C) == MASK_C);
         default:    tick = 1'b1;
      endcase
   end
endmodule

// File: rtl/pgf_core.sv
module pgf_core #(
   parameter int AGREE = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_d,
   input  logic sync_vld,
   input  logic bypass,
   input  logic tick,
   output logic level,
   output logic rise_p,
   output logic fall_p,
   output logic primed
);
   generate
      if (AGREE < 2) begin : g_bad_agree
         $error("pgf_core: AGREE must be at least 2");
      end
   endgenerate

   logic [AGREE-2:0] hist;
   logic [AGREE-1:0] window;
   logic             agree;
   logic             accept;

   assign window = {hist, sync_d};
   assign agree  = (&window) | (~|window);
   assign accept = bypass | (tick & agree);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist   <= '0;
         level  <= 1'b0;
         rise_p <= 1'b0;
         fall_p <= 1'b0;
         primed <= 1'b0;
      end else begin
         rise_p <= 1'b0;
         fall_p <= 1'b0;
         if (!primed) begin
            if (sync_vld) begin
               primed <= 1'b1;
               level  <= sync_d;
               hist   <= {(AGREE-1){sync_d}};
            end
         end else begin
            if (tick) hist <= window[AGREE-2:0];
            if (accept && (sync_d != level)) begin
               level  <= sync_d;
               rise_p <= sync_d;
               fall_p <= ~sync_d;
            end
         end
      end
   end
endmodule

// File: rtl/pgf_edge.sv
module pgf_edge (
   input  logic rise_p,
   input  logic fall_p,
   input  logic rise_sel,
   input  logic both_edges,
   output logic evt
);
   always_comb begin
      if (both_edges)    evt = rise_p | fall_p;
      else if (rise_sel) evt = rise_p;
      else               evt = fall_p;
   end
endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int AGREE_COUNT = 3,
   parameter int DIV_W       = 5,
   parameter int SH_A        = 1,
   parameter int SH_B        = 3,
   parameter int SH_C        = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_raw,
   input  logic [1:0] rate_sel,
   input  logic       rise_sel,
   input  logic       both_edges,
   output logic       level_out,
   output logic       edge_evt
);
   import pgf_pkg::*;

   logic sync_d;
   logic sync_vld;
   logic sample_tick;
   logic primed;
   logic rise_p;
   logic fall_p;
   logic bypass;

   assign bypass = (rate_sel == RATE_OFF);

   pgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(sync_d), .vld(sync_vld)
   );

   pgf_tick #(.DIV_W(DIV_W), .SH_A(SH_A), .SH_B(SH_B), .SH_C(SH_C)) u_tick (
      .clk(clk), .rst_n(rst_n), .sel(rate_sel), .tick(sample_tick)
   );

   pgf_core #(.AGREE(AGREE_COUNT)) u_core (
      .clk(clk), .rst_n(rst_n), .sync_d(sync_d), .sync_vld(sync_vld),
      .bypass(bypass), .tick(sample_tick), .level(level_out),
      .rise_p(rise_p), .fall_p(fall_p), .primed(primed)
   );

   pgf_edge u_edge (
      .rise_p(rise_p), .fall_p(fall_p), .rise_sel(rise_sel),
      .both_edges(both_edges), .evt(edge_evt)
   );
endmodule

// File: rtl/pgf_chk.sv
module pgf_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] rate_sel,
   input logic       rise_sel,
   input logic       both_edges,
   input logic       level_out,
   input logic       edge_evt,
   input logic       primed,
   input logic       sample_tick
);
   // R8
   evt_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt |-> (level_out != $past(level_out)));

   // R9
   no_evt_before_prime_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !primed |-> !edge_evt);

   // R2
   filtered_change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(rate_sel) != 2'b00) && $past(primed) && (level_out != $past(level_out)))
      |-> $past(sample_tick));

   // R6
   both_edges_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (both_edges && $past(primed) && (level_out != $past(level_out))) |-> edge_evt);

   // R7
   rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!both_edges && rise_sel && edge_evt) |-> level_out);

   // R7
   fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!both_edges && !rise_sel && edge_evt) |-> !level_out);
endmodule

bind pin_glitch_filter pgf_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .rise_sel(rise_sel),
   .both_edges(both_edges), .level_out(level_out), .edge_evt(edge_evt),
   .primed(primed), .sample_tick(sample_tick)
);

// File: tb/pin_glitch_filter_tb.sv
module pin_glitch_filter_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      bit    rise;
      int    lo;
      int    hi;
      string req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_raw = 1'b1;
   logic [1:0] rate_sel = 2'b00;
   logic       rise_sel = 1'b1;
   logic       both_edges = 1'b1;
   logic       level_out;
   logic       edge_evt;

   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   int   evt_seen = 0;
   int   cur_n = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   pin_glitch_filter u_dut (
      .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .rate_sel(rate_sel),
      .rise_sel(rise_sel), .both_edges(both_edges),
      .level_out(level_out), .edge_evt(edge_evt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on each event
   always @(negedge clk) begin
      if (rst_n && edge_evt) begin
         evt_seen++;
         if (sb.size() == 0) begin
            check(1'b0, "R8", "unexpected edge event, level", int'(level_out), -1);
         end else begin
            exp_t it;
            it = sb.pop_front();
            check(level_out == it.rise, it.req, "event direction (level)",
                  int'(level_out), int'(it.rise));
            check(cyc >= it.lo && cyc <= it.hi, it.req, "event cycle vs earliest",
                  cyc, it.lo);
         end
      end
   end

   // driver: sets the pin and pushes the expected event
   task automatic set_pin(bit v, int hold, bit accepted, string req);
      @(negedge clk);
      pin_raw = v;
      if (accepted && (both_edges || (rise_sel == v))) begin
         exp_t it;
         it.rise = v;
         it.req  = req;
         if (cur_n == 0) begin
            it.lo = cyc + 3;
            it.hi = cyc + 3;
         end else begin
            it.lo = cyc + 3 + 2*cur_n;
            it.hi = cyc + 2 + 3*cur_n;
         end
         sb.push_back(it);
      end
      repeat (hold - 1) @(negedge clk);
   endtask

   task automatic drain(int wait_n, string req);
      repeat (wait_n) @(negedge clk);
      check(sb.size() == 0, req, "pending expected events", sb.size(), 0);
   endtask

   task automatic set_rate(logic [1:0] code);
      @(negedge clk);
      rate_sel = code;
      case (code)
         2'b01:   cur_n = 2;
         2'b10:   cur_n = 8;
         2'b11:   cur_n = 32;
         default: cur_n = 0;
      endcase
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not end, cycle %0d expected below %0d", cyc, 200000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R9: reset state with pin held high
      repeat (5) @(negedge clk);
      check(level_out == 1'b0, "R9", "level_out in reset", int'(level_out), 0);
      check(edge_evt == 1'b0, "R9", "edge_evt in reset", int'(edge_evt), 0);
      rst_n = 1'b1;
      repeat (8) @(negedge clk);
      check(level_out == 1'b1, "R9", "level_out after priming", int'(level_out), 1);
      check(evt_seen == 0, "R9", "events during priming", evt_seen, 0);

      // R1 / R5: bypass exact latency, one-clock low pulse
      set_pin(1'b0, 1, 1'b1, "R1");
      set_pin(1'b1, 6, 1'b1, "R5");
      drain(4, "R5");
      check(evt_seen == 2, "R5", "events from one-clock pulse", evt_seen, 2);

      // R6: bypass, both edges, wider pulse
      set_pin(1'b0, 5, 1'b1, "R6");
      set_pin(1'b1, 5, 1'b1, "R6");
      drain(4, "R6");

      // R7: rising only, then falling only
      both_edges = 1'b0;
      rise_sel   = 1'b1;
      set_pin(1'b0, 6, 1'b1, "R7");
      check(level_out == 1'b0, "R7", "level follows fall with rise-only", int'(level_out), 0);
      set_pin(1'b1, 6, 1'b1, "R7");
      drain(4, "R7");
      rise_sel = 1'b0;
      set_pin(1'b0, 6, 1'b1, "R7");
      set_pin(1'b1, 6, 1'b1, "R7");
      check(level_out == 1'b1, "R7", "level follows rise with fall-only", int'(level_out), 1);
      drain(4, "R7");
      both_edges = 1'b1;

      // R2 / R3 / R4: each filtered rate
      for (int code = 1; code <= 3; code++) begin
         set_rate(2'(code));
         // R3: longest pulse that must be rejected
         set_pin(1'b0, 2*cur_n, 1'b0, "R3");
         set_pin(1'b1, 3*cur_n + 8, 1'b0, "R3");
         check(level_out == 1'b1, "R3", "level after 2N glitch", int'(level_out), 1);
         drain(2, "R3");
         // R4 / R2: shortest pulse that must be accepted
         set_pin(1'b0, 3*cur_n, 1'b1, "R4");
         set_pin(1'b1, 3*cur_n + 8, 1'b1, "R2");
         drain(4, "R4");
         check(level_out == 1'b1, "R4", "level after accepted pulse", int'(level_out), 1);
      end

      // R7 with filtering: rising only at clk/8
      set_rate(2'b10);
      both_edges = 1'b0;
      rise_sel   = 1'b1;
      set_pin(1'b0, 3*cur_n + 4, 1'b1, "R7");
      check(level_out == 1'b0, "R7", "filtered level after low", int'(level_out), 0);
      set_pin(1'b1, 3*cur_n + 8, 1'b1, "R7");
      drain(4, "R7");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule